// File: doc/BRIEF.md
# I2C Target with Control-Byte Addressing

This block is an I2C target that turns bus transactions into single-byte accesses on a simple internal port. After the master addresses it for writing, the first byte is a control byte. It gives the width of the access address (one, two or four bytes) and says whether the master means to write data or to read it back. The address bytes follow, most significant first. After them the master either streams write data or issues a repeated start with the read bit set and then collects data.

The block samples SCL and SDA, which must already be synchronised to `clk`, and pulls SDA low only through an open-drain enable. Each written byte becomes a one-cycle write strobe carrying address and data. Each byte to be sent becomes a one-cycle read request, and the data port must answer on the next clock. The access address moves up by one after every data byte.

Top module: `i2c_cbt_target`

## Requirements
- R1: A slave-address byte whose upper seven bits differ from `DEV_ADDR` gets no acknowledge, and every later byte is ignored (no acknowledge, no access) until the next start condition.
- R2: With the R/W bit 0, the byte after the slave address is a control byte. Bits [2:1] set the address length: 00 means one byte, 01 two bytes, 10 four bytes. Bit 0 = 0 announces a write and bit 0 = 1 a read. A valid control byte is acknowledged.
- R3: A control byte with bits [2:1] = 11, or with any of bits [7:3] set, gets no acknowledge, and the rest of the transaction is ignored until the next start.
- R4: Exactly as many address bytes as the control byte selects are taken and acknowledged, most significant byte first. They are zero-extended into the access address.
- R5: In a write, each data byte after the last address byte is acknowledged and produces one single-cycle `wr_en` pulse. The pulse carries the byte and the current access address, and the address then moves up by one.
- R6: In a read setup, the last address byte is acknowledged and the address is held. A repeated start with the slave address and R/W bit 1 is then acknowledged. Data bytes are returned MSB first. Each byte comes from a one-cycle `rd_req` with `rd_addr`, with `rd_data` captured one clock after `rd_req` is high.
- R7: In a read, a master acknowledge fetches the next byte from the following address. A master NAK releases SDA, and no further `rd_req` is issued before the next start.
- R8: A read-direction slave address with no pending read setup gets no acknowledge.
- R9: A start condition at any point restarts slave-address reception. A stop returns the block to idle and discards any pending read setup.
- R10: SDA is only ever pulled low through `sda_oe`. The enable changes only in the clock after SCL falls, or at a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | PTR_W | Write access address |
| wr_data | output | 8 | Write data byte |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | PTR_W | Read access address |
| rd_data | input | 8 | Read data, valid the clock after rd_req |

## Verification
The hardest state to reach is the held read setup. Only a complete write-direction transaction with a read control byte creates it. It must then survive, or be lost, across a repeated start, a stop, or bytes the master sends in between. The stimulus walks a bus-level master through full setup sequences in 8-bit and 32-bit forms. It then tries a read after a stop and a read with no setup at all, and checks the acknowledge bit and the request log in each case. A start is also forced in the middle of a data byte, and the next full transaction must behave normally.

// File: rtl/i2c_cbt_pkg.sv
package i2c_cbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_CTRL, ST_ADDR, ST_WDATA, ST_WAITRS, ST_RDATA, ST_SKIP
  } cbt_state_e;

  // reserved upper bits must be zero and size code 11 is not allowed
  function automatic logic ctrl_ok(input logic [7:0] b);
    return (b[7:3] == 5'd0) && (b[2:1] != 2'b11);
  endfunction

  // number of access-address bytes selected by the size field
  function automatic logic [2:0] ctrl_addr_bytes(input logic [7:0] b);
    case (b[2:1])
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/i2c_cbt_bus_events.sv
module i2c_cbt_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_cbt_shifter.sv
module i2c_cbt_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              ack_rise,
  output logic              ack_end,
  output logic              bit_fall,
  output logic [CNT_W-1:0]  bit_idx
);
  logic [CNT_W-1:0] cnt;
  logic             in_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      in_ack  <= 1'b0;
      rx_byte <= '0;
    end else if (clr) begin
      cnt    <= '0;
      in_ack <= 1'b0;
    end else if (scl_rise) begin
      if (!in_ack && cnt < CNT_W'(BYTE_W)) begin
        rx_byte <= {rx_byte[BYTE_W-2:0], sda_i};
        cnt     <= cnt + 1'b1;
      end
    end else if (scl_fall) begin
      if (in_ack) begin
        in_ack <= 1'b0;
        cnt    <= '0;
      end else if (cnt == CNT_W'(BYTE_W)) begin
        in_ack <= 1'b1;
      end
    end
  end

  assign byte_done = scl_fall & ~in_ack & (cnt == CNT_W'(BYTE_W));
  assign ack_rise  = scl_rise & in_ack;
  assign ack_end   = scl_fall & in_ack;
  assign bit_fall  = scl_fall & ~in_ack & (cnt != '0) & (cnt != CNT_W'(BYTE_W));
  assign bit_idx   = cnt;

  // R9: a start or stop always leaves the bit counter at the byte boundary
  assert_clr_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !in_ack));

endmodule

// File: rtl/i2c_cbt_target.sv
module i2c_cbt_target
  import i2c_cbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h52,
  parameter int         PTR_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_req,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rx;
  logic byte_done, ack_rise, ack_end, bit_fall;
  logic [CNT_W-1:0] bit_idx;

  cbt_state_e       st, nxt;
  logic             dir_rd, armed, mack, rd_req_d;
  logic [2:0]       addr_left;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       tx;
  logic             dev_hit;

  i2c_cbt_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_cbt_shifter #(.BYTE_W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .clr(start_det | stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_i(sda_i),
    .rx_byte(rx), .byte_done(byte_done), .ack_rise(ack_rise),
    .ack_end(ack_end), .bit_fall(bit_fall), .bit_idx(bit_idx)
  );

  assign dev_hit = (rx[7:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE;
      sda_oe <= 1'b0; wr_en <= 1'b0; rd_req <= 1'b0; rd_req_d <= 1'b0;
      wr_addr <= '0; wr_data <= '0; rd_addr <= '0;
      dir_rd <= 1'b0; armed <= 1'b0; mack <= 1'b0;
      addr_left <= '0; ptr <= '0; tx <= '0;
    end else begin
      wr_en    <= 1'b0;
      rd_req   <= 1'b0;
      rd_req_d <= rd_req;
      if (rd_req_d) tx <= rd_data;
      if (start_det) begin
        st <= ST_DEV;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE;
        sda_oe <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (byte_done) begin
          nxt <= st;
          unique case (st)
            ST_DEV: begin
              nxt <= ST_SKIP;
              if (dev_hit && !rx[0]) begin
                sda_oe <= 1'b1;
                nxt <= ST_CTRL;
              end else if (dev_hit && armed) begin
                sda_oe <= 1'b1;
                nxt <= ST_RDATA;
                armed <= 1'b0;
                rd_req <= 1'b1;
                rd_addr <= ptr;
                ptr <= ptr + 1'b1;
              end
            end
            ST_CTRL: begin
              nxt <= ST_SKIP;
              if (ctrl_ok(rx)) begin
                sda_oe <= 1'b1;
                dir_rd <= rx[0];
                addr_left <= ctrl_addr_bytes(rx);
                ptr <= '0;
                armed <= 1'b0;
                nxt <= ST_ADDR;
              end
            end
            ST_ADDR: begin
              sda_oe <= 1'b1;
              ptr <= {ptr[PTR_W-9:0], rx};
              addr_left <= addr_left - 1'b1;
              if (addr_left == 3'd1) begin
                nxt <= dir_rd ? ST_WAITRS : ST_WDATA;
                armed <= dir_rd;
              end
            end
            ST_WDATA: begin
              sda_oe <= 1'b1;
              wr_en <= 1'b1;
              wr_addr <= ptr;
              wr_data <= rx;
              ptr <= ptr + 1'b1;
            end
            ST_RDATA: sda_oe <= 1'b0;
            default: ;
          endcase
        end
        if (ack_rise && st == ST_RDATA) begin
          mack <= ~sda_i;
          if (!sda_i) begin
            rd_req <= 1'b1;
            rd_addr <= ptr;
            ptr <= ptr + 1'b1;
          end
        end
        if (ack_end) begin
          st <= nxt;
          sda_oe <= 1'b0;
          if (nxt == ST_RDATA) begin
            if (st != ST_RDATA || mack) sda_oe <= ~tx[7];
            else st <= ST_SKIP;
          end
        end
        if (bit_fall && st == ST_RDATA) sda_oe <= ~tx[3'd7 - bit_idx[2:0]];
      end
    end
  end

  // R10: the enable only turns on in the clock after SCL has fallen
  assert_oe_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));
  // R3: a rejected control byte is never acknowledged
  assert_bad_ctrl_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_CTRL && !ctrl_ok(rx)) |=> !sda_oe);
  // R1: a foreign slave address is never acknowledged
  assert_foreign_nak_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == ST_DEV && !dev_hit) |=> !sda_oe);
  // R5: each write strobe lasts a single clock
  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R6: read requests only appear on the way into or inside a read
  assert_rdreq_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (st == ST_RDATA || nxt == ST_RDATA));
  // R9: start releases SDA and re-enters slave-address reception; stop disarms
  assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_DEV && !sda_oe));
  assert_stop_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!armed && st == ST_IDLE));

endmodule

// File: tb/i2c_cbt_target_tb.sv
module i2c_cbt_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;
  localparam logic [6:0] DEV = 7'h52;
  localparam int NV = 5;
  localparam logic [7:0]  TV_CTRL [NV] = '{8'h02, 8'h00, 8'h04, 8'h06, 8'h0A};
  localparam logic [31:0] TV_ADDR [NV] = '{32'h00001234, 32'h000000AB, 32'hDEADBE01, 32'h0, 32'h0};
  localparam logic        TV_OK   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en, rd_req;
  logic [31:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data = 8'h00;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int wcnt = 0, rcnt = 0, oe_viol = 0;
  logic [31:0] wlog_a [16];
  logic [7:0]  wlog_d [16];
  logic [31:0] rlog_a [16];
  logic oe_prev = 1'b0, scl_prev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cbt_target #(.DEV_ADDR(DEV), .PTR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] mem_f(input logic [31:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= mem_f(rd_addr);

  always @(negedge clk) begin
    if (wr_en) begin wlog_a[wcnt % 16] = wr_addr; wlog_d[wcnt % 16] = wr_data; wcnt++; end
    if (rd_req) begin rlog_a[rcnt % 16] = rd_addr; rcnt++; end
    if (sda_oe !== oe_prev && scl_m && scl_prev) oe_viol++;
    oe_prev = sda_oe;
    scl_prev = scl_m;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(); repeat (HP) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wt(); scl_m = 1; wt(); sda_m = 0; wt(); scl_m = 0; wt(); endtask
  task automatic bus_stop(); sda_m = 0; wt(); scl_m = 1; wt(); sda_m = 1; wt(); endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(); scl_m = 1; wt(); scl_m = 0;
    end
    sda_m = 1; wt(); scl_m = 1; wt();
    ack = (sda_line == 1'b0);
    scl_m = 0; wt();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(); scl_m = 1; wt(); b[i] = sda_line; scl_m = 0;
    end
    wt(); sda_m = ~give_ack; wt(); scl_m = 1; wt(); scl_m = 0; wt(); sda_m = 1;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int w0, r0, nb;
    repeat (3) @(negedge clk);
    chk("reset sda_oe R10", {31'd0, sda_oe}, 32'd0);
    chk("reset wr_en R5", {31'd0, wr_en}, 32'd0);
    chk("reset rd_req R6", {31'd0, rd_req}, 32'd0);
    rst_n = 1'b1;
    wt();

    // table walk: write transactions, R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      w0 = wcnt;
      bus_start();
      send_byte({DEV, 1'b0}, ack); chk("dev ack R1", {31'd0, ack}, 32'd1);
      send_byte(TV_CTRL[v], ack);  chk("ctrl ack R2/R3", {31'd0, ack}, {31'd0, TV_OK[v]});
      if (TV_OK[v]) begin
        nb = (TV_CTRL[v][2:1] == 2'b00) ? 1 : (TV_CTRL[v][2:1] == 2'b01) ? 2 : 4;
        for (int k = nb - 1; k >= 0; k--) begin
          send_byte(TV_ADDR[v][8*k +: 8], ack); chk("addr ack R4", {31'd0, ack}, 32'd1);
        end
      end
      send_byte(8'h40 + 8'(v), ack); chk("data0 ack R5/R3", {31'd0, ack}, {31'd0, TV_OK[v]});
      send_byte(8'h80 + 8'(v), ack); chk("data1 ack R5/R3", {31'd0, ack}, {31'd0, TV_OK[v]});
      bus_stop();
      chk("write count R5/R3", wcnt - w0, TV_OK[v] ? 32'd2 : 32'd0);
      if (TV_OK[v]) begin
        chk("wr addr0 R4", wlog_a[w0 % 16], TV_ADDR[v]);
        chk("wr addr1 R5", wlog_a[(w0 + 1) % 16], TV_ADDR[v] + 1);
        chk("wr data0 R5", {24'd0, wlog_d[w0 % 16]}, 32'h40 + v);
        chk("wr data1 R5", {24'd0, wlog_d[(w0 + 1) % 16]}, 32'h80 + v);
      end
    end

    // R1: foreign address, following bytes ignored
    w0 = wcnt;
    bus_start();
    send_byte({7'h21, 1'b0}, ack); chk("foreign nak R1", {31'd0, ack}, 32'd0);
    send_byte(8'h00, ack); chk("ignored ctrl R1", {31'd0, ack}, 32'd0);
    send_byte(8'h11, ack); chk("ignored byte R1", {31'd0, ack}, 32'd0);
    bus_stop();
    chk("no write R1", wcnt - w0, 32'd0);

    // R8: read with no setup
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("unarmed read nak R8", {31'd0, ack}, 32'd0);
    bus_stop();

    // R6 R7: 32-bit read setup 0x05, three bytes, NAK on last
    r0 = rcnt;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h05, ack); chk("ctrl 05 ack R2", {31'd0, ack}, 32'd1);
    send_byte(8'h10, ack); send_byte(8'h20, ack); send_byte(8'h30, ack);
    send_byte(8'h40, ack); chk("last addr ack R6", {31'd0, ack}, 32'd1);
    chk("no early rd_req R6", rcnt - r0, 32'd0);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("read addr ack R6", {31'd0, ack}, 32'd1);
    recv_byte(1'b1, rb); chk("rd byte0 R6", {24'd0, rb}, {24'd0, mem_f(32'h10203040)});
    recv_byte(1'b1, rb); chk("rd byte1 R7", {24'd0, rb}, {24'd0, mem_f(32'h10203041)});
    recv_byte(1'b0, rb); chk("rd byte2 R7", {24'd0, rb}, {24'd0, mem_f(32'h10203042)});
    chk("released after nak R7", {31'd0, sda_oe}, 32'd0);
    bus_stop();
    chk("rd_req count R7", rcnt - r0, 32'd3);
    chk("rd addr0 R6", rlog_a[r0 % 16], 32'h10203040);
    chk("rd addr2 R7", rlog_a[(r0 + 2) % 16], 32'h10203042);

    // R6 R4: 8-bit read, single byte
    bus_start();
    send_byte({DEV, 1'b0}, ack); send_byte(8'h01, ack); send_byte(8'h7F, ack);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("8b read ack R6", {31'd0, ack}, 32'd1);
    recv_byte(1'b0, rb); chk("8b rd byte R4", {24'd0, rb}, {24'd0, mem_f(32'h7F)});
    bus_stop();

    // R9: stop discards a pending read setup
    bus_start();
    send_byte({DEV, 1'b0}, ack); send_byte(8'h01, ack); send_byte(8'h10, ack);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("stop disarm R9", {31'd0, ack}, 32'd0);
    bus_stop();

    // R9: start in the middle of a data byte
    w0 = wcnt;
    bus_start();
    send_byte({DEV, 1'b0}, ack); send_byte(8'h00, ack); send_byte(8'h20, ack);
    for (int i = 0; i < 3; i++) begin sda_m = i[0]; wt(); scl_m = 1; wt(); scl_m = 0; end
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("restart dev ack R9", {31'd0, ack}, 32'd1);
    send_byte(8'h00, ack); send_byte(8'h30, ack);
    send_byte(8'h99, ack); chk("restart data ack R9", {31'd0, ack}, 32'd1);
    bus_stop();
    chk("restart write count R9", wcnt - w0, 32'd1);
    chk("restart write addr R9", wlog_a[w0 % 16], 32'h30);
    chk("restart write data R9", {24'd0, wlog_d[w0 % 16]}, 32'h99);

    // R10: enable never moved while SCL stayed high
    chk("oe timing R10", oe_viol, 32'd0);
    finish_run();
  end
endmodule